// File: doc/BRIEF.md
# Non-Volatile Store Program Controller

This block decides when a channel setting that has just arrived over the serial port is copied into its non-volatile slot, and it runs the erase/write cycle that follows. The serial receiver reports two events: a strobe when the start bit of a frame is seen, and a strobe together with the channel address and data byte when the last data bit has been clocked in. The controller tracks the program request line across the frame. It accepts a request only when that line rises after the start bit and is still high on the clock edge that follows the last data bit.

An accepted request pulls the active-low ready/busy output low for a parameterised number of clock cycles. Throughout that time the clock must keep running. The program line must stay high for a minimum number of those cycles. At the end of the count the addressed slot is written through a one-cycle write port, and the slots themselves are held in registers inside the block. A hold signal tells the serial receiver to ignore its input and keep its output quiet from the edge after the last data bit until the inter-frame gap has elapsed.

The ready/busy output is combined with a supply-low flag. When the supply is too low, a program command leaves the output high and nothing is stored. A drop of the supply during the cycle ends it without a store.

Top module: `pv_nvprog_ctrl`

## Requirements
- R1: A store is accepted only if `prog` is sampled low and then high on two consecutive rising edges while a frame is open, the first of these edges falling after the edge that saw `frm_start`. `prog` must also be high on the edge that follows the edge which saw `frm_done`. Otherwise `rdy_bsy_n` stays high and `st_we` never pulses for that frame.
- R2: After an accepted request, `rdy_bsy_n` is low for exactly EW_CYC cycles, beginning right after the acceptance edge. In the cycle after that, `st_we` is high for one cycle with `st_addr`/`st_data` equal to the address and data latched at `frm_done`, and `rdy_bsy_n` is high again.
- R3: `busy_hold` is high from the edge that saw `frm_done` until the gap ends. While it is high, `frm_start` and `frm_done` are ignored, so a second frame sent during a busy cycle causes no extra write.
- R4: If `supply_low` is high on the acceptance edge, the cycle is refused: `rdy_bsy_n` stays high and no write occurs. While `supply_low` is high, `rdy_bsy_n` is high. If `supply_low` is sampled high during the busy cycle, the cycle ends without a write.
- R5: If `prog` is sampled low on any of the first PULSE_CYC edges of the busy cycle, the cycle aborts: `rdy_bsy_n` returns high at once and no write occurs.
- R6: After the busy cycle, or after a frame that ends without a store, the controller ignores `frm_start` for GAP_CYC cycles. A `frm_start` sampled in the cycle after the gap opens a new frame.
- R7: Slot i of `nv_image` occupies bits [i*8 +: 8]. Only the slot addressed by a write changes, and it takes `st_data` on the edge that ends the `st_we` cycle. No slot changes in any other cycle.
- R8: During and after reset, `rdy_bsy_n` is 1, `busy_hold` is 0, `st_we` is 0, and every slot of `nv_image` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also times the erase/write cycle |
| rst | input | 1 | Synchronous active-high reset |
| prog | input | 1 | Program request line |
| frm_start | input | 1 | One-cycle strobe: start bit seen by the serial receiver |
| frm_done | input | 1 | One-cycle strobe: last data bit received |
| frm_addr | input | 2 | Channel address delivered with `frm_done` |
| frm_data | input | 8 | Setting delivered with `frm_done` |
| supply_low | input | 1 | Supply below programming minimum |
| rdy_bsy_n | output | 1 | Low while an erase/write cycle runs |
| busy_hold | output | 1 | Tells the serial receiver to ignore input and quiet its output |
| st_we | output | 1 | Storage write strobe, one cycle |
| st_addr | output | 2 | Storage write slot |
| st_data | output | 8 | Storage write data |
| nv_image | output | 32 | Contents of all non-volatile slots |

## Verification
The program line is driven in several shapes. It can rise correctly inside the frame and stay high. It can already be high before the start bit, rise and then fall before the acceptance edge, stay low throughout, or fall early inside the minimum pulse width. Comparing these shapes separates the rising-edge window check from the level check at acceptance, and both from the pulse-width abort. The supply-low flag is tried both at acceptance and in the middle of the cycle, which shows a refusal apart from an abort. A second frame sent during a busy cycle, and start bits placed in the last gap cycle and in the first free cycle, fix the blocking and gap boundaries to the exact cycle.

// File: rtl/pv_pkg.sv
package pv_pkg;

    localparam int NV_ADDR_W   = 2;
    localparam int NV_DATA_W   = 8;
    localparam int NV_CHANNELS = 1 << NV_ADDR_W;
    localparam int NV_IMAGE_W  = NV_CHANNELS * NV_DATA_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FRAME,
        ST_POST,
        ST_BUSY,
        ST_GAP
    } pv_state_e;

    typedef struct packed {
        logic                 we;
        logic [NV_ADDR_W-1:0] addr;
        logic [NV_DATA_W-1:0] data;
    } pv_wr_t;

    function automatic logic window_state(pv_state_e s);
        return (s == ST_FRAME) || (s == ST_POST);
    endfunction

    function automatic logic hold_state(pv_state_e s);
        return (s == ST_POST) || (s == ST_BUSY) || (s == ST_GAP);
    endfunction

endpackage

// File: rtl/pv_window.sv
module pv_window (
    input  logic clk,
    input  logic rst,
    input  logic open_i,
    input  logic prog_i,
    output logic ok_o
);
    logic prog_q;
    logic armed_q;
    logic rise;

    assign rise = prog_i & ~prog_q;
    assign ok_o = prog_i & (armed_q | rise);

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            prog_q  <= prog_i;
            armed_q <= open_i ? (armed_q | rise) : 1'b0;
        end
    end
endmodule

// File: rtl/pv_seq.sv
module pv_seq
    import pv_pkg::*;
#(
    parameter int PULSE_CYC = 6,
    parameter int EW_CYC    = 10,
    parameter int GAP_CYC   = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frm_start_i,
    input  logic                 frm_done_i,
    input  logic [NV_ADDR_W-1:0] frm_addr_i,
    input  logic [NV_DATA_W-1:0] frm_data_i,
    input  logic                 prog_i,
    input  logic                 supply_low_i,
    input  logic                 win_ok_i,
    output logic                 win_open_o,
    output logic                 busy_o,
    output logic                 hold_o,
    output pv_wr_t               wr_o
);
    localparam int CNT_W = $clog2(EW_CYC + 1);
    localparam int GAP_W = $clog2(GAP_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(EW_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_PULSE = CNT_W'(PULSE_CYC);
    localparam logic [GAP_W-1:0] GAP_LAST  = GAP_W'(GAP_CYC - 1);

    pv_state_e            state;
    logic [CNT_W-1:0]     cnt;
    logic [GAP_W-1:0]     gcnt;
    logic [NV_ADDR_W-1:0] lat_addr;
    logic [NV_DATA_W-1:0] lat_data;
    pv_wr_t               wr_q;
    logic                 early_drop;

    assign early_drop = ~prog_i & (cnt < CNT_PULSE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            gcnt     <= '0;
            lat_addr <= '0;
            lat_data <= '0;
            wr_q     <= '0;
        end else begin
            wr_q.we <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (frm_start_i) state <= ST_FRAME;
                end
                ST_FRAME: begin
                    if (frm_done_i) begin
                        lat_addr <= frm_addr_i;
                        lat_data <= frm_data_i;
                        state    <= ST_POST;
                    end
                end
                ST_POST: begin
                    gcnt <= '0;
                    cnt  <= '0;
                    if (win_ok_i && !supply_low_i) state <= ST_BUSY;
                    else                           state <= ST_GAP;
                end
                ST_BUSY: begin
                    if (supply_low_i || early_drop) begin
                        state <= ST_GAP;
                    end else if (cnt == CNT_LAST) begin
                        wr_q.we   <= 1'b1;
                        wr_q.addr <= lat_addr;
                        wr_q.data <= lat_data;
                        state     <= ST_GAP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (gcnt == GAP_LAST) state <= ST_IDLE;
                    else                  gcnt  <= gcnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign win_open_o = window_state(state);
    assign hold_o     = hold_state(state);
    assign busy_o     = (state == ST_BUSY);
    assign wr_o       = wr_q;
endmodule

// File: rtl/pv_slots.sv
module pv_slots
    import pv_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  pv_wr_t                wr_i,
    output logic [NV_IMAGE_W-1:0] image_o
);
    for (genvar g = 0; g < NV_CHANNELS; g++) begin : g_slot
        logic [NV_DATA_W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst)
                slot_q <= '0;
            else if (wr_i.we && (wr_i.addr == NV_ADDR_W'(g)))
                slot_q <= wr_i.data;
        end
        assign image_o[g*NV_DATA_W +: NV_DATA_W] = slot_q;
    end
endmodule

// File: rtl/pv_nvprog_ctrl.sv
module pv_nvprog_ctrl
    import pv_pkg::*;
#(
    parameter int PULSE_CYC = 6,
    parameter int EW_CYC    = 10,
    parameter int GAP_CYC   = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  prog,
    input  logic                  frm_start,
    input  logic                  frm_done,
    input  logic [NV_ADDR_W-1:0]  frm_addr,
    input  logic [NV_DATA_W-1:0]  frm_data,
    input  logic                  supply_low,
    output logic                  rdy_bsy_n,
    output logic                  busy_hold,
    output logic                  st_we,
    output logic [NV_ADDR_W-1:0]  st_addr,
    output logic [NV_DATA_W-1:0]  st_data,
    output logic [NV_IMAGE_W-1:0] nv_image
);
    logic   win_open;
    logic   win_ok;
    logic   busy;
    pv_wr_t wr;

    pv_window u_window (
        .clk    (clk),
        .rst    (rst),
        .open_i (win_open),
        .prog_i (prog),
        .ok_o   (win_ok)
    );

    pv_seq #(
        .PULSE_CYC (PULSE_CYC),
        .EW_CYC    (EW_CYC),
        .GAP_CYC   (GAP_CYC)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .frm_start_i  (frm_start),
        .frm_done_i   (frm_done),
        .frm_addr_i   (frm_addr),
        .frm_data_i   (frm_data),
        .prog_i       (prog),
        .supply_low_i (supply_low),
        .win_ok_i     (win_ok),
        .win_open_o   (win_open),
        .busy_o       (busy),
        .hold_o       (busy_hold),
        .wr_o         (wr)
    );

    pv_slots u_slots (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (wr),
        .image_o (nv_image)
    );

    assign rdy_bsy_n = ~busy | supply_low;
    assign st_we     = wr.we;
    assign st_addr   = wr.addr;
    assign st_data   = wr.data;
endmodule

// File: rtl/pv_nvprog_ctrl_chk.sv
module pv_nvprog_ctrl_chk #(
    parameter int IMG_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             supply_low,
    input logic             rdy_bsy_n,
    input logic             busy_hold,
    input logic             st_we,
    input logic [IMG_W-1:0] nv_image
);
    AST_WRITE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        st_we |-> ($past(!rdy_bsy_n) && rdy_bsy_n)); // R2

    AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        st_we |=> !st_we); // R2

    AST_BUSY_HOLDS_SERIAL: assert property (@(posedge clk) disable iff (rst)
        !rdy_bsy_n |-> busy_hold); // R3

    AST_NO_WRITE_LOW_SUPPLY: assert property (@(posedge clk) disable iff (rst)
        st_we |-> !$past(supply_low)); // R4

    AST_IMAGE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !st_we |=> $stable(nv_image)); // R7
endmodule

bind pv_nvprog_ctrl pv_nvprog_ctrl_chk #(.IMG_W(pv_pkg::NV_IMAGE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .supply_low (supply_low),
    .rdy_bsy_n  (rdy_bsy_n),
    .busy_hold  (busy_hold),
    .st_we      (st_we),
    .nv_image   (nv_image)
);

// File: tb/pv_nvprog_ctrl_bench.sv
module pv_nvprog_ctrl_bench;
    localparam int PULSE_CYC = 6;
    localparam int EW_CYC    = 10;
    localparam int GAP_CYC   = 2;
    localparam int OBS_CYC   = EW_CYC + GAP_CYC + 4;
    localparam int NVEC      = 10;

    // vector: mode[17:15] addr[14:13] data[12:5] expected-low-cycles[4:0]
    // modes: 0 prog idle, 1 good, 2 prog high before start, 3 early drop,
    //        4 supply low at accept, 5 prog falls before accept,
    //        6 supply low mid-cycle, 7 good plus frame sent while busy
    localparam logic [17:0] VECS [NVEC] = '{
        {3'd1, 2'd0, 8'h5A, 5'd10},
        {3'd1, 2'd3, 8'hC3, 5'd10},
        {3'd2, 2'd1, 8'h11, 5'd0},
        {3'd0, 2'd2, 8'h22, 5'd0},
        {3'd3, 2'd1, 8'h33, 5'd2},
        {3'd4, 2'd2, 8'h44, 5'd0},
        {3'd5, 2'd0, 8'h55, 5'd0},
        {3'd6, 2'd3, 8'h66, 5'd3},
        {3'd7, 2'd0, 8'h77, 5'd10},
        {3'd1, 2'd2, 8'h81, 5'd10}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog = 1'b0;
    logic        frm_start = 1'b0;
    logic        frm_done = 1'b0;
    logic [1:0]  frm_addr = '0;
    logic [7:0]  frm_data = '0;
    logic        supply_low = 1'b0;
    logic        rdy_bsy_n;
    logic        busy_hold;
    logic        st_we;
    logic [1:0]  st_addr;
    logic [7:0]  st_data;
    logic [31:0] nv_image;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model [4];
    int obs_low, obs_we, obs_lowviol;
    logic [1:0] obs_addr;
    logic [7:0] obs_data;
    logic post_hold;

    always #5 clk = ~clk;

    pv_nvprog_ctrl #(.PULSE_CYC(PULSE_CYC), .EW_CYC(EW_CYC), .GAP_CYC(GAP_CYC)) u_pv_nvprog_ctrl (
        .clk(clk), .rst(rst), .prog(prog), .frm_start(frm_start), .frm_done(frm_done),
        .frm_addr(frm_addr), .frm_data(frm_data), .supply_low(supply_low),
        .rdy_bsy_n(rdy_bsy_n), .busy_hold(busy_hold), .st_we(st_we),
        .st_addr(st_addr), .st_data(st_data), .nv_image(nv_image)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_image(input string req);
        for (int i = 0; i < 4; i++)
            check(req, $sformatf("slot %0d", i), int'(nv_image[i*8 +: 8]), int'(model[i]));
    endtask

    // frm_start is already high at the current negedge
    task automatic frame_body(input int mode, input logic [1:0] a, input logic [7:0] d,
                              input bit stop_on_we);
        @(negedge clk);
        frm_start = 1'b0;
        if (mode == 1 || mode == 3 || mode == 5 || mode == 6 || mode == 7) prog = 1'b1;
        supply_low = (mode == 4);
        @(negedge clk);
        frm_done = 1'b1; frm_addr = a; frm_data = d;
        if (mode == 5) prog = 1'b0;
        @(negedge clk);
        frm_done = 1'b0;
        post_hold = busy_hold;
        obs_low = 0; obs_we = 0; obs_lowviol = 0; obs_addr = '0; obs_data = '0;
        for (int i = 0; i < OBS_CYC; i++) begin
            @(negedge clk);
            if (!rdy_bsy_n) obs_low++;
            if (supply_low && !rdy_bsy_n) obs_lowviol++;
            if (st_we) begin obs_we++; obs_addr = st_addr; obs_data = st_data; end
            if (stop_on_we && st_we) break;
            if (mode == 3 && i == 1) prog = 1'b0;
            if (mode == 6 && i == 2) supply_low = 1'b1;
            if (mode == 7 && i == 2) frm_start = 1'b1;
            if (mode == 7 && i == 3) begin
                frm_start = 1'b0; frm_done = 1'b1; frm_addr = a ^ 2'd1; frm_data = ~d;
            end
            if (mode == 7 && i == 4) frm_done = 1'b0;
        end
        prog = 1'b0;
        supply_low = 1'b0;
    endtask

    task automatic run_frame(input int mode, input logic [1:0] a, input logic [7:0] d);
        if (mode == 2) begin @(negedge clk); prog = 1'b1; end
        @(negedge clk);
        frm_start = 1'b1;
        frame_body(mode, a, d, 1'b0);
    endtask

    function automatic string req_of(input int mode);
        case (mode)
            1: return "R2";
            3: return "R5";
            4, 6: return "R4";
            7: return "R3";
            default: return "R1";
        endcase
    endfunction

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R8: state while in reset and after release
        check("R8", "rdy during reset", int'(rdy_bsy_n), 1);
        rst = 1'b0;
        @(negedge clk);
        check("R8", "rdy after reset", int'(rdy_bsy_n), 1);
        check("R8", "hold after reset", int'(busy_hold), 0);
        check("R8", "we after reset", int'(st_we), 0);
        check_image("R8");

        for (int v = 0; v < NVEC; v++) begin
            int mode, elow;
            logic [1:0] a;
            logic [7:0] d;
            bit wr;
            mode = int'(VECS[v][17:15]);
            a    = VECS[v][14:13];
            d    = VECS[v][12:5];
            elow = int'(VECS[v][4:0]);
            wr   = (mode == 1 || mode == 7);
            run_frame(mode, a, d);
            check("R3", $sformatf("vec %0d hold after last bit", v), int'(post_hold), 1);
            check(req_of(mode), $sformatf("vec %0d busy cycles", v), obs_low, elow);
            check(req_of(mode), $sformatf("vec %0d write count", v), obs_we, wr ? 1 : 0);
            check("R4", $sformatf("vec %0d rdy low under low supply", v), obs_lowviol, 0);
            if (wr) begin
                check("R2", $sformatf("vec %0d write addr", v), int'(obs_addr), int'(a));
                check("R2", $sformatf("vec %0d write data", v), int'(obs_data), int'(d));
                model[a] = d;
            end
            check_image("R7");
        end

        // R6: start bit in the last gap cycle is ignored
        @(negedge clk);
        frm_start = 1'b1;
        frame_body(1, 2'd3, 8'h9C, 1'b1);
        check("R6", "write before gap test", obs_we, 1);
        model[3] = 8'h9C;
        @(negedge clk);
        frm_start = 1'b1; prog = 1'b0;
        frame_body(1, 2'd1, 8'hE1, 1'b0);
        check("R6", "start in last gap cycle: busy", obs_low, 0);
        check("R6", "start in last gap cycle: write", obs_we, 0);
        check_image("R6");

        // R6: start bit in the first free cycle is accepted
        @(negedge clk);
        frm_start = 1'b1;
        frame_body(1, 2'd2, 8'h3D, 1'b1);
        check("R6", "write before boundary", obs_we, 1);
        model[2] = 8'h3D;
        @(negedge clk);
        @(negedge clk);
        frm_start = 1'b1; prog = 1'b0;
        frame_body(1, 2'd0, 8'hB4, 1'b0);
        check("R6", "start after gap: busy", obs_low, EW_CYC);
        check("R6", "start after gap: write", obs_we, 1);
        model[0] = 8'hB4;
        check_image("R7");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule